// File: doc/BRIEF.md
# SDLC Transmit Idle-Line Sequencer

This block decides which 8-bit pattern a bit-oriented synchronous transmitter shifts out at each byte slot. Between frames it fills the line with idle bytes. The idle byte is either the flag `0x7E` or the all-ones mark byte `0xFF`, chosen by a select input. Around each frame it places exactly one opening flag and one closing flag. The line runs one bit per clock. Zero-bit insertion, CRC and line coding belong to later stages; this block only picks the byte that is loaded at each boundary.

The idle select is looked at only at the last bit of a byte. A change of the select in the middle of a byte therefore never cuts a pattern short. While loop mode is high the select has no effect and idle slots carry flags. Once loop mode drops, the value on the select applies again at the next boundary. A frame starts only when data is offered and mark idle is off. While mark idle is on, pending data waits behind all-ones bytes. Data bytes are taken through a valid/ready handshake. Ready rises only at a byte boundary inside a frame. A frame-end request is remembered until the frame runs out of data, and then the closing flag is sent.

Top module: `sdlc_idle_seq`

## Requirements
- R1: Out of a frame, with the select low (or loop mode high) and no data offered, each idle slot carries the flag `0x7E`.
- R2: Out of a frame, with the select high and loop mode low, each idle slot carries `0xFF`, even when data is offered.
- R3: The select is sampled only in the last bit-cycle of a byte, so each idle slot is one whole flag or one whole `0xFF`, decided by the select's value in that cycle.
- R4: When data is offered out of a frame and the effective select is low, the next slot is an opening flag, and the data byte goes out in the slot after it.
- R5: While loop mode is high the select has no effect (idle slots are flags); after loop mode drops, the select applies from the next boundary on.
- R6: After reset the line carries a flag (first bit 0), the strobe is low, ready is low, and the block is out of a frame.
- R7: `byte_strobe` pulses for one cycle with the first bit of every new byte, exactly `BYTE_W` cycles apart; bytes go out least significant bit first.
- R8: `data_ready` is high only in the last bit-cycle of a byte while in a frame; a byte with `data_valid` high at that time is sent in the next slot.
- R9: A frame-end request made in a frame is held. When a boundary finds no data offered and the request pending, one closing flag is sent and the block leaves the frame.
- R10: In a frame with no data offered and no frame-end pending, the slot is filled with a flag and the frame stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_idle | input | 1 | Idle select: 0 flags, 1 all ones |
| loop_mode | input | 1 | Loop mode active; select is ignored while high |
| data_valid | input | 1 | A frame data byte is offered |
| data_byte | input | BYTE_W | Offered data byte |
| frame_end | input | 1 | Request to close the current frame |
| data_ready | output | 1 | Offered byte is taken this cycle |
| ser_out | output | 1 | Serial line bit |
| byte_strobe | output | 1 | First bit of a new byte is on the line |

## Verification
On every cycle the assertions check the strobe spacing and the one-cycle pulse width. They also check that ready appears only at a boundary inside a frame. From the first bit of the next byte, they check that idle loads out of a frame match the select and the loop mode. Only the bench scenarios can show complete byte sequences. These are opening-flag placement, data waiting behind mark idle, a single closing flag after a held frame-end request, flag fill on underrun, and the select change in the middle of a byte.

// File: rtl/sdlc_idle_pkg.sv
package sdlc_idle_pkg;
   localparam logic [7:0] FLAG_PAT = 8'h7E;
   localparam logic [7:0] MARK_PAT = 8'hFF;

   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_FRAME = 1'b1
   } seq_st_t;
endpackage

// File: rtl/sdlc_idle_bitctr.sv
module sdlc_idle_bitctr #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic boundary
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign boundary = (cnt_q == LAST);
endmodule

// File: rtl/sdlc_idle_pick.sv
module sdlc_idle_pick
   import sdlc_idle_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              mark_idle,
   input  logic              loop_mode,
   input  logic              data_valid,
   input  logic [BYTE_W-1:0] data_byte,
   input  logic              frame_end,
   output logic [BYTE_W-1:0] next_byte,
   output logic              data_ready,
   output logic              in_frame
);
   seq_st_t st_q, st_d;
   logic    end_pend_q;
   logic    close_now;
   logic    mark_eff;

   assign mark_eff = mark_idle & ~loop_mode;

   always_comb begin
      st_d      = st_q;
      next_byte = FLAG_PAT;
      close_now = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (data_valid && !mark_eff) begin
               next_byte = FLAG_PAT;
               st_d      = ST_FRAME;
            end else begin
               next_byte = mark_eff ? MARK_PAT : FLAG_PAT;
            end
         end
         ST_FRAME: begin
            if (data_valid) begin
               next_byte = data_byte;
            end else if (end_pend_q) begin
               next_byte = FLAG_PAT;
               close_now = 1'b1;
               st_d      = ST_IDLE;
            end else begin
               next_byte = FLAG_PAT;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         end_pend_q <= 1'b0;
      end else begin
         if (boundary) st_q <= st_d;
         if (boundary && close_now)           end_pend_q <= 1'b0;
         else if (frame_end && st_q == ST_FRAME) end_pend_q <= 1'b1;
      end
   end

   assign data_ready = boundary && (st_q == ST_FRAME);
   assign in_frame   = (st_q == ST_FRAME);
endmodule

// File: rtl/sdlc_idle_shifter.sv
module sdlc_idle_shifter
   import sdlc_idle_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] din,
   output logic              sout,
   output logic              strobe
);
   logic [BYTE_W-1:0] sh_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk) begin
            if (!rst_n)    sh_q <= FLAG_PAT;
            else if (load) sh_q <= din;
            else           sh_q <= {1'b1, sh_q[BYTE_W-1:1]};
         end
         assign sout = sh_q[0];
      end else begin : g_msb
         always_ff @(posedge clk) begin
            if (!rst_n)    sh_q <= FLAG_PAT;
            else if (load) sh_q <= din;
            else           sh_q <= {sh_q[BYTE_W-2:0], 1'b1};
         end
         assign sout = sh_q[BYTE_W-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) strobe <= 1'b0;
      else        strobe <= load;
   end
endmodule

// File: rtl/sdlc_idle_seq.sv
module sdlc_idle_seq
   import sdlc_idle_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mark_idle,
   input  logic              loop_mode,
   input  logic              data_valid,
   input  logic [BYTE_W-1:0] data_byte,
   input  logic              frame_end,
   output logic              data_ready,
   output logic              ser_out,
   output logic              byte_strobe
);
   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("sdlc_idle_seq: BYTE_W must be 8 to hold flag patterns");
      end
   endgenerate

   logic              load_en;
   logic              in_frame;
   logic [BYTE_W-1:0] pick_byte;

   sdlc_idle_bitctr #(.BYTE_W(BYTE_W)) ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (load_en)
   );

   sdlc_idle_pick #(.BYTE_W(BYTE_W)) pick_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary   (load_en),
      .mark_idle  (mark_idle),
      .loop_mode  (loop_mode),
      .data_valid (data_valid),
      .data_byte  (data_byte),
      .frame_end  (frame_end),
      .next_byte  (pick_byte),
      .data_ready (data_ready),
      .in_frame   (in_frame)
   );

   sdlc_idle_shifter #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) shf_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_en),
      .din    (pick_byte),
      .sout   (ser_out),
      .strobe (byte_strobe)
   );
endmodule

// File: rtl/sdlc_idle_seq_chk.sv
module sdlc_idle_seq_chk #(
   parameter int BYTE_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic mark_idle,
   input logic loop_mode,
   input logic data_valid,
   input logic data_ready,
   input logic ser_out,
   input logic byte_strobe,
   input logic load_en,
   input logic in_frame
);
   localparam int GAP_W = $clog2(BYTE_W + 2) + 1;

   logic [GAP_W-1:0] gap_q;
   logic             seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (byte_strobe) begin
         gap_q  <= GAP_W'(1);
         seen_q <= 1'b1;
      end else if (gap_q != '1) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   // R7: strobe spacing and width
   a_r7_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_strobe && seen_q) |-> (gap_q == GAP_W'(BYTE_W)));
   a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      byte_strobe |=> !byte_strobe);

   // R8: ready only at a boundary inside a frame
   a_r8_ready_edge: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |-> (load_en && in_frame));

   // R1: flag idle starts with a 0 bit
   a_r1_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !in_frame && (!mark_idle || loop_mode)) |=> !ser_out);

   // R2: mark idle starts with a 1 bit
   a_r2_mark_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !in_frame && mark_idle && !loop_mode) |=> ser_out);

   // R5: loop mode forces flag idle
   a_r5_loop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !in_frame && loop_mode) |=> (!ser_out && byte_strobe));

   // R2: no frame opens under mark idle
   a_r2_no_open: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !in_frame && mark_idle && !loop_mode) |=> !in_frame);
endmodule

bind sdlc_idle_seq sdlc_idle_seq_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .mark_idle   (mark_idle),
   .loop_mode   (loop_mode),
   .data_valid  (data_valid),
   .data_ready  (data_ready),
   .ser_out     (ser_out),
   .byte_strobe (byte_strobe),
   .load_en     (load_en),
   .in_frame    (in_frame)
);

// File: tb/sdlc_idle_seq_tb.sv
module sdlc_idle_seq_tb_top;
   localparam int BW = 8;
   localparam logic [7:0] FLG = 8'h7E;
   localparam logic [7:0] MRK = 8'hFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mark_idle = 1'b0;
   logic          loop_mode = 1'b0;
   logic          data_valid = 1'b0;
   logic [BW-1:0] data_byte = '0;
   logic          frame_end = 1'b0;
   logic          data_ready;
   logic          ser_out;
   logic          byte_strobe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   sdlc_idle_seq #(.BYTE_W(BW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mark_idle   (mark_idle),
      .loop_mode   (loop_mode),
      .data_valid  (data_valid),
      .data_byte   (data_byte),
      .frame_end   (frame_end),
      .data_ready  (data_ready),
      .ser_out     (ser_out),
      .byte_strobe (byte_strobe)
   );

   // Monitor: rebuild each byte LSB first from its strobe and compare
   logic [7:0] cur;
   int         idx = 0;
   bit         active = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_strobe) begin
            cur    = '0;
            idx    = 0;
            active = 1'b1;
         end
         if (active) begin
            cur[idx] = ser_out;
            idx++;
            if (idx == 8) begin
               active = 1'b0;
               if (exp_q.size() > 0) begin
                  logic [7:0] e;
                  string      t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  checks++;
                  if (cur !== e) begin
                     fails++;
                     $display("FAIL %s: byte got %h expected %h", t, cur, e);
                  end
               end
            end
         end
      end
   end

   task automatic push(input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic wait_strobe();
      @(negedge clk);
      while (!byte_strobe) @(negedge clk);
   endtask

   // Driver: set inputs at a byte start; they decide the following byte
   task automatic slot(input bit mk, input bit lp, input bit dv,
                       input logic [7:0] d, input bit fe,
                       input logic [7:0] e, input string t);
      wait_strobe();
      mark_idle  = mk;
      loop_mode  = lp;
      data_valid = dv;
      data_byte  = d;
      frame_end  = fe;
      push(e, t);
   endtask

   task automatic slot_mid(input bit first, input bit last,
                           input logic [7:0] e, input string t);
      wait_strobe();
      mark_idle  = first;
      loop_mode  = 1'b0;
      data_valid = 1'b0;
      frame_end  = 1'b0;
      push(e, t);
      repeat (3) @(negedge clk);
      mark_idle = last;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R6: reset state
      checks++;
      if (ser_out !== 1'b0) begin
         fails++; $display("FAIL R6: ser_out got %b expected 0", ser_out);
      end
      checks++;
      if (byte_strobe !== 1'b0) begin
         fails++; $display("FAIL R6: byte_strobe got %b expected 0", byte_strobe);
      end
      checks++;
      if (data_ready !== 1'b0) begin
         fails++; $display("FAIL R6: data_ready got %b expected 0", data_ready);
      end
      push(FLG, "R6 first idle byte");
      rst_n = 1'b1;

      // R1 flag idle
      slot(0, 0, 0, 8'h00, 0, FLG, "R1 flag idle");
      slot(0, 0, 0, 8'h00, 0, FLG, "R1 flag idle");
      // R2 mark idle, data held back
      slot(1, 0, 0, 8'h00, 0, MRK, "R2 mark idle");
      slot(1, 0, 1, 8'hA5, 0, MRK, "R2 data waits under mark");
      // R4 opening flag then data
      slot(0, 0, 1, 8'hA5, 0, FLG, "R4 opening flag");
      slot(0, 0, 1, 8'hA5, 0, 8'hA5, "R8 first data byte");
      slot(1, 0, 1, 8'h3C, 1, 8'h3C, "R8 second data byte");
      // R9 closing flag after held request, then mark idle
      slot(1, 0, 0, 8'h00, 0, FLG, "R9 closing flag");
      slot(1, 0, 0, 8'h00, 0, MRK, "R9 mark idle after close");
      // R10 underrun fill
      slot(0, 0, 1, 8'h81, 0, FLG, "R4 opening flag 2");
      slot(0, 0, 0, 8'h00, 0, FLG, "R10 underrun flag fill");
      slot(0, 0, 1, 8'h81, 0, 8'h81, "R10 frame still open");
      slot(0, 0, 0, 8'h00, 1, FLG, "R9 close on empty");
      slot(0, 0, 0, 8'h00, 0, FLG, "R1 idle after close");
      // R5 loop mode
      slot(1, 1, 0, 8'h00, 0, FLG, "R5 loop ignores select");
      slot(1, 1, 1, 8'h55, 0, FLG, "R5 loop opening flag");
      slot(1, 1, 1, 8'h55, 0, 8'h55, "R5 loop data");
      slot(1, 0, 0, 8'h00, 1, FLG, "R9 loop close");
      slot(1, 0, 0, 8'h00, 0, MRK, "R5 select applies after loop");
      // R3 select sampled at boundary
      slot_mid(0, 1, MRK, "R3 late set to mark");
      slot_mid(1, 0, FLG, "R3 late clear to flag");
      slot(0, 0, 0, 8'h00, 0, FLG, "R7 steady flag");

      while (exp_q.size() > 0) @(negedge clk);
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
      end
   end
endmodule